// File: doc/BRIEF.md
# Selectable-Rate Step Tick Generator

This block turns a fast system clock into a slow step strobe whose rate is set by a two-bit speed code. The rate is chosen from four rates that halve one after another. Division happens in two stages. A long prescaler brings the system clock down to a base tick rate, nominally 8 Hz from 10 MHz. A short binary counter then advances on each base tick, and its low bits supply the half, quarter and eighth rates.

The output is a one-cycle enable pulse in the system clock domain, not a derived clock. Logic downstream that advances on each step can therefore stay on the system clock. The prescale ratio is a parameter. A bench can use a ratio of a few cycles, and hardware uses the full ratio.

Top module: `step_rate_gen`

## Requirements
- R1: While `rst` is high at a rising edge, both counters clear and `step_en` is low in the following cycle. After release, counting restarts from the beginning, and the first base tick comes PRESCALE cycles after the first edge with `rst` low.
- R2: A base tick occurs on every PRESCALE-th rising edge with `rst` low. Each base tick advances the 3-bit rate counter by one, wrapping from 7 to 0. Between base ticks the rate counter holds its value.
- R3: With `speed` = 2'b11 (8 Hz), every base tick produces a `step_en` pulse, so pulses are exactly PRESCALE cycles apart.
- R4: With `speed` = 2'b10 (4 Hz), a pulse is issued only on base ticks where rate counter bit 0 is 1, which is every 2nd base tick.
- R5: With `speed` = 2'b01 (2 Hz), a pulse is issued only on base ticks where rate counter bits 1:0 are both 1, which is every 4th base tick.
- R6: With `speed` = 2'b00 (1 Hz), a pulse is issued only on the base tick where the rate counter is 7, which is every 8th base tick.
- R7: `step_en` is registered. It is high in the cycle right after a qualifying base tick, and it is never high in two consecutive cycles.
- R8: A change of `speed` takes effect from the next qualifying base tick. `step_en` rises only in the cycle after a base tick, so a speed change produces no extra pulse between base ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| speed | input | 2 | Rate code: 00 = 1 Hz, 01 = 2 Hz, 10 = 4 Hz, 11 = 8 Hz |
| step_en | output | 1 | One-cycle step strobe at the selected rate |

## Verification
The hardest case to reach is a change of speed code that lands exactly on, or just before, a base tick while the rate counter is partway through a slow period. The output must follow the new code only from that base tick onward. The bench uses a small prescale ratio so that base ticks come every few cycles. It changes the speed code at random intervals of a few cycles and inserts occasional mid-period resets. A cycle-accurate bench model tracks base tick positions as arithmetic on an index, and the output is compared against that model on every cycle.

// File: rtl/step_rate_pkg.sv
package step_rate_pkg;
  localparam int TREE_MAXW = 16;

  // True when the k least significant bits of v are all set (k = 0 is always true).
  function automatic logic low_bits_set(input logic [TREE_MAXW-1:0] v, input int k);
    logic r;
    r = 1'b1;
    for (int i = 0; i < TREE_MAXW; i++) begin
      if (i < k && !v[i]) r = 1'b0;
    end
    return r;
  endfunction

  // Map a speed code to the number of halvings below the base rate.
  function automatic int halvings(input int code, input int depth);
    int h;
    h = depth - code;
    if (h < 0) h = 0;
    return h;
  endfunction
endpackage

// File: rtl/step_prescaler.sv
module step_prescaler #(
  parameter int PRESCALE = 1250000
) (
  input  logic clk,
  input  logic rst,
  output logic base_tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pcnt;

  assign base_tick = !rst && (pcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
    end else if (pcnt == LAST) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/step_rate_tree.sv
module step_rate_tree
  import step_rate_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_tick,
  output logic [DEPTH-1:0] tree_cnt,
  output logic [DEPTH:0]   rate_hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tree_cnt <= '0;
    end else if (base_tick) begin
      tree_cnt <= tree_cnt + 1'b1;
    end
  end

  // rate_hit[j]: the rate divided by 2^j qualifies on this base tick
  for (genvar j = 0; j <= DEPTH; j++) begin : g_rate
    assign rate_hit[j] = low_bits_set(TREE_MAXW'(tree_cnt), j);
  end
endmodule

// File: rtl/step_rate_select.sv
module step_rate_select
  import step_rate_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int SPD_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_tick,
  input  logic [SPD_W-1:0] speed,
  input  logic [DEPTH:0]   rate_hit,
  output logic             step_en
);
  logic chosen;

  always_comb begin
    chosen = 1'b0;
    for (int j = 0; j <= DEPTH; j++) begin
      if (j == halvings(int'(speed), DEPTH)) chosen = rate_hit[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_en <= 1'b0;
    end else begin
      step_en <= base_tick && chosen;
    end
  end
endmodule

// File: rtl/step_rate_gen.sv
module step_rate_gen #(
  parameter int PRESCALE = 1250000,
  parameter int DEPTH    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] speed,
  output logic       step_en
);
  localparam int SPD_W = $clog2(DEPTH + 1);

  logic             base_tick;
  logic [DEPTH-1:0] tree_cnt;
  logic [DEPTH:0]   rate_hit;

  step_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .base_tick(base_tick)
  );

  step_rate_tree #(.DEPTH(DEPTH)) u_tree (
    .clk(clk), .rst(rst), .base_tick(base_tick),
    .tree_cnt(tree_cnt), .rate_hit(rate_hit)
  );

  step_rate_select #(.DEPTH(DEPTH), .SPD_W(SPD_W)) u_sel (
    .clk(clk), .rst(rst), .base_tick(base_tick),
    .speed(SPD_W'(speed)), .rate_hit(rate_hit), .step_en(step_en)
  );
endmodule

// File: rtl/step_rate_gen_chk.sv
module step_rate_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] speed,
  input logic       step_en,
  input logic       base_tick,
  input logic [2:0] tree_cnt
);
  AST_RST_QUIET: assert property (@(posedge clk) rst |=> !step_en); // R1
  AST_TREE_ADV: assert property (@(posedge clk) disable iff (rst)
    base_tick |=> tree_cnt == 3'($past(tree_cnt) + 3'd1)); // R2
  AST_TREE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !base_tick |=> $stable(tree_cnt)); // R2
  AST_FAST_EVERY: assert property (@(posedge clk) disable iff (rst)
    (base_tick && speed == 2'b11) |=> step_en); // R3
  AST_HALF_SKIP: assert property (@(posedge clk) disable iff (rst)
    (base_tick && speed == 2'b10 && !tree_cnt[0]) |=> !step_en); // R4
  AST_QUARTER_SKIP: assert property (@(posedge clk) disable iff (rst)
    (base_tick && speed == 2'b01 && tree_cnt[1:0] != 2'b11) |=> !step_en); // R5
  AST_SLOW_SKIP: assert property (@(posedge clk) disable iff (rst)
    (base_tick && speed == 2'b00 && tree_cnt != 3'd7) |=> !step_en); // R6
  AST_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    step_en |=> !step_en); // R7
  AST_ON_BASE: assert property (@(posedge clk) disable iff (rst)
    $rose(step_en) |-> $past(base_tick)); // R8
endmodule

bind step_rate_gen step_rate_gen_chk u_chk (
  .clk(clk), .rst(rst), .speed(speed), .step_en(step_en),
  .base_tick(base_tick), .tree_cnt(tree_cnt[2:0])
);

// File: tb/step_rate_gen_tb_top.sv
module step_rate_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] speed = 2'b11;
  logic       step_en;

  int tests = 0;
  int fails = 0;
  int mp = 0;        // model prescale position
  int mb = 0;        // model base tick index since reset
  int since_chg = 1000;
  logic prev_step = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_rate_gen #(.PRESCALE(P)) dut_i (
    .clk(clk), .rst(rst), .speed(speed), .step_en(step_en)
  );

  // Base tick number b qualifies when (b+1) is a multiple of 2^(3-code).
  function automatic logic qualifies(input int b, input logic [1:0] code);
    int per;
    per = 1 << (3 - int'(code));
    return ((b + 1) % per) == 0;
  endfunction

  function automatic string tag_for(input logic r, input logic [1:0] code, input int chg);
    if (r) return "R1";
    if (chg < 8 * P) return "R8";
    case (code)
      2'b11: return "R3";
      2'b10: return "R4";
      2'b01: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Advance one cycle; the model uses inputs held during the past edge.
  task automatic tick();
    logic exp;
    @(negedge clk);
    if (rst) begin
      exp = 1'b0; mp = 0; mb = 0;
    end else begin
      exp = (mp == P - 1) && qualifies(mb, speed);
      if (mp == P - 1) begin mp = 0; mb++; end else mp++;
    end
    check(tag_for(rst, speed, since_chg), int'(step_en), int'(exp), "step_en per cycle");
    if (prev_step && step_en) check("R7", 1, 0, "consecutive pulse");
    prev_step = step_en;
    since_chg++;
  endtask

  task automatic set_speed(input logic [1:0] s);
    if (s != speed) since_chg = 0;
    speed = s;
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      tick();
      check("R1", int'(step_en), 0, "step_en in reset");
    end
    rst = 1'b0;
  endtask

  initial begin
    int cnt;
    int first;
    int last;
    do_reset(3);
    check("R1", int'(step_en), 0, "reset state");

    // R1/R2/R3: first pulse and spacing at 8 Hz
    first = -1; last = -1; cnt = 0;
    for (int c = 1; c <= 6 * P; c++) begin
      tick();
      if (step_en) begin
        if (first < 0) first = c;
        else check("R2", c - last, P, "pulse spacing at speed 11");
        last = c;
        cnt++;
      end
    end
    check("R1", first, P, "first pulse cycle after release");
    check("R3", cnt, 6, "pulses in 6 base periods");

    // R3..R6: pulses in 8 base periods per speed code
    for (int s = 0; s < 4; s++) begin
      set_speed(2'(s));
      since_chg = 1000;
      do_reset(2);
      cnt = 0;
      for (int c = 0; c < 8 * P; c++) begin
        tick();
        if (step_en) cnt++;
      end
      check(s == 3 ? "R3" : s == 2 ? "R4" : s == 1 ? "R5" : "R6", cnt, 1 << s,
            "pulses per 8 base periods");
    end

    // R8: switch slow -> fast mid period, pulse must come at the next base tick
    set_speed(2'b00);
    do_reset(2);
    for (int c = 0; c < 2 * P + 2; c++) tick();
    set_speed(2'b11);
    cnt = 0;
    for (int c = 0; c < P; c++) begin
      tick();
      if (step_en) cnt++;
    end
    check("R8", cnt, 1, "pulses in one base period after switch to 11");
    set_speed(2'b00);
    cnt = 0;
    for (int c = 0; c < 3 * P; c++) begin
      tick();
      if (step_en) cnt++;
    end
    check("R8", cnt, 0, "no pulse after switch to 00 before count 7");

    // Random phase with fixed seed
    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 6) == 0) set_speed(2'($urandom_range(0, 3)));
      if ($urandom_range(0, 300) == 0) begin
        do_reset($urandom_range(1, 3));
      end
      tick();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule